// File: doc/BRIEF.md
# Iterative Signed/Unsigned Multiplier

This block is the multiply unit of a small processor's execute stage. It turns two 32-bit operands into a 64-bit product using a single adder. Each clock it performs one conditional add followed by a right shift, so one full product takes 32 clocks. One mode input picks how the operands are read. When it is high, both operands are unsigned. When it is low, both are two's-complement signed values. The same datapath serves both modes.

The processor raises `run` when a multiply instruction reaches execute, and it keeps `run` high until the instruction retires. The block drives `stall` high while it is still working, which freezes the pipeline. `stall` drops in the cycle after the last step, and the 64-bit result is then on `product`. The block reads the operands and the mode only in the first step cycle. After the final step the result stays on `product` until a new operation begins. If `run` drops before the work is done, the block abandons the operation and returns to idle. A new operation needs `run` low for at least one cycle before it starts.

Top module: `iter_mul_top`

## Requirements
- R1: After reset, `stall` is low and `product` is zero.
- R2: With `mode_unsigned` = 1, the final `product` equals the unsigned 64-bit product of `op_a` and `op_b`.
- R3: With `mode_unsigned` = 0, the final `product` equals the signed 64-bit product of `op_a` and `op_b`, for every sign combination. This includes -2^31 times -2^31, which gives 2^62.
- R4: From the cycle in which `run` rises, with `run` held high, `stall` is high for exactly 32 consecutive cycles and then low.
- R5: `stall` is never high while `run` is low, and it rises in the same cycle as `run` (combinational path from `run`).
- R6: After completion, `product` stays unchanged while `run` stays high, and also after `run` falls, until the next operation starts.
- R7: If `run` falls before completion, including during the final step cycle, `stall` is low at once. The next operation then starts from step zero and gives a correct product.
- R8: `op_a`, `op_b` and `mode_unsigned` are sampled only in the first step cycle. Changing them in later step cycles has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | High while a multiply instruction occupies execute |
| mode_unsigned | input | 1 | 1: unsigned operands, 0: signed operands |
| op_a | input | 32 | Multiplicand |
| op_b | input | 32 | Multiplier |
| stall | output | 1 | High while the product is not yet ready |
| product | output | 64 | Product register, final after `stall` drops |

## Verification
The hardest coincidence is `run` falling in the same cycle as the final add-shift step, so that the abandon and the completion meet. The bench raises `run`, holds it through 31 stall cycles, and drops it just before the edge that would finish the operation. It then requires `stall` to be low at once and the next full operation to produce the exact reference product. A second overlap sits on the first step, where the operand sampling meets the stepping. The bench changes the operands and the mode right after that edge and requires the product of the original values.

// File: rtl/iter_mul_pkg.sv
package iter_mul_pkg;

    localparam int unsigned MUL_W_DEFAULT = 32;

    typedef enum logic {
        MODE_SIGNED   = 1'b0,
        MODE_UNSIGNED = 1'b1
    } mul_mode_e;

endpackage

// File: rtl/iter_mul_step.sv
module iter_mul_step #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] hi_in,
    input  logic [W-1:0] lo_in,
    input  logic [W-1:0] mcand,
    input  logic         is_signed,
    input  logic         last_step,
    output logic [W-1:0] hi_out,
    output logic [W-1:0] lo_out
);
    localparam int unsigned EW = W + 1;

    logic [EW-1:0] ext_hi;
    logic [EW-1:0] ext_a;
    logic [EW-1:0] sum;

    always_comb begin
        ext_hi = {is_signed & hi_in[W-1], hi_in};
        ext_a  = {is_signed & mcand[W-1], mcand};
        if (lo_in[0]) begin
            if (is_signed && last_step) begin
                sum = ext_hi - ext_a;
            end else begin
                sum = ext_hi + ext_a;
            end
        end else begin
            sum = ext_hi;
        end
        hi_out = sum[EW-1:1];
        lo_out = {sum[0], lo_in[W-1:1]};
    end
endmodule

// File: rtl/iter_mul_ctrl.sv
module iter_mul_ctrl #(
    parameter int unsigned W = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic step_en,
    output logic first_step,
    output logic last_step
);
    localparam int unsigned CNT_W = $clog2(W);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(W - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             done;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        step_en    = run & ~st_q.done;
        first_step = step_en & (st_q.cnt == '0);
        last_step  = step_en & (st_q.cnt == LAST_CNT);
        if (!run) begin
            st_d.cnt  = '0;
            st_d.done = 1'b0;
        end else if (!st_q.done) begin
            if (st_q.cnt == LAST_CNT) begin
                st_d.done = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R7: dropping run always returns the sequencer to idle
    a_r7_abandon_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (st_q.cnt == '0) && !st_q.done);

    // R4: the counter advances one per step until it finishes
    a_r4_count_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !st_q.done && st_q.cnt != LAST_CNT) |=> (st_q.cnt == $past(st_q.cnt) + 1'b1) && !st_q.done);

    // R4: finishing only happens out of the final count
    a_r4_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.done) |-> ($past(st_q.cnt) == LAST_CNT));
endmodule

// File: rtl/iter_mul_datapath.sv
module iter_mul_datapath #(
    parameter int unsigned W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           step_en,
    input  logic           first_step,
    input  logic           last_step,
    input  logic           mode_unsigned,
    input  logic [W-1:0]   op_a,
    input  logic [W-1:0]   op_b,
    output logic [2*W-1:0] product
);
    import iter_mul_pkg::*;

    typedef struct packed {
        logic [W-1:0] hi;
        logic [W-1:0] lo;
        logic [W-1:0] mcand;
        logic         sgn;
    } dp_state_t;

    dp_state_t dp_d, dp_q;

    logic [W-1:0] cur_hi, cur_lo, cur_a;
    logic         cur_sgn;
    logic [W-1:0] nxt_hi, nxt_lo;

    always_comb begin
        if (first_step) begin
            cur_hi  = '0;
            cur_lo  = op_b;
            cur_a   = op_a;
            cur_sgn = (mul_mode_e'(mode_unsigned) == MODE_SIGNED);
        end else begin
            cur_hi  = dp_q.hi;
            cur_lo  = dp_q.lo;
            cur_a   = dp_q.mcand;
            cur_sgn = dp_q.sgn;
        end
    end

    iter_mul_step #(.W(W)) step_i (
        .hi_in     (cur_hi),
        .lo_in     (cur_lo),
        .mcand     (cur_a),
        .is_signed (cur_sgn),
        .last_step (last_step),
        .hi_out    (nxt_hi),
        .lo_out    (nxt_lo)
    );

    always_comb begin
        dp_d = dp_q;
        if (step_en) begin
            dp_d.hi    = nxt_hi;
            dp_d.lo    = nxt_lo;
            dp_d.mcand = cur_a;
            dp_d.sgn   = cur_sgn;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign product = {dp_q.hi, dp_q.lo};

    // R6: without a step the product register does not move
    a_r6_hold_product: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> $stable(product));

    // R8: operands latched on the first step stay put for later steps
    a_r8_operands_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !first_step) |=> $stable(dp_q.mcand) && $stable(dp_q.sgn));
endmodule

// File: rtl/iter_mul_top.sv
module iter_mul_top #(
    parameter int unsigned W = iter_mul_pkg::MUL_W_DEFAULT
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic           mode_unsigned,
    input  logic [W-1:0]   op_a,
    input  logic [W-1:0]   op_b,
    output logic           stall,
    output logic [2*W-1:0] product
);
    logic step_en, first_step, last_step;

    iter_mul_ctrl #(.W(W)) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .step_en    (step_en),
        .first_step (first_step),
        .last_step  (last_step)
    );

    iter_mul_datapath #(.W(W)) dp_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .step_en       (step_en),
        .first_step    (first_step),
        .last_step     (last_step),
        .mode_unsigned (mode_unsigned),
        .op_a          (op_a),
        .op_b          (op_b),
        .product       (product)
    );

    assign stall = step_en;

    // R5: the pipeline is only frozen while a multiply is present
    a_r5_stall_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> run);
endmodule

// File: tb/iter_mul_top_tb_top.sv
module iter_mul_top_tb_top;
    localparam int unsigned W = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run = 1'b0;
    logic          mode_unsigned = 1'b0;
    logic [W-1:0]  op_a = '0;
    logic [W-1:0]  op_b = '0;
    logic          stall;
    logic [63:0]   product;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    iter_mul_top #(.W(W)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .run           (run),
        .mode_unsigned (mode_unsigned),
        .op_a          (op_a),
        .op_b          (op_b),
        .stall         (stall),
        .product       (product)
    );

    function automatic logic [63:0] ref_prod(input logic [31:0] a, input logic [31:0] b, input logic uns);
        longint sa, sb;
        if (uns) return {32'd0, a} * {32'd0, b};
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        return 64'(sa * sb);
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Full operation; optionally scrambles inputs after the first step (R8).
    task automatic do_mul(input logic [31:0] a, input logic [31:0] b, input logic uns, input bit scramble);
        int n;
        logic [63:0] exp;
        exp = ref_prod(a, b, uns);
        @(negedge clk);
        op_a = a; op_b = b; mode_unsigned = uns; run = 1'b1;
        #1;
        check(stall === 1'b1, "R5 stall rises with run", 64'(stall), 64'd1);
        n = 0;
        while (stall === 1'b1 && n < 40) begin
            n++;
            @(negedge clk);
            if (scramble) begin
                op_a = $urandom; op_b = $urandom; mode_unsigned = ~uns;
            end
            #1;
        end
        check(n == 32, "R4 stall length", 64'(n), 64'd32);
        if (scramble)
            check(product === exp, "R8 late input change ignored", product, exp);
        else if (uns)
            check(product === exp, "R2 unsigned product", product, exp);
        else
            check(product === exp, "R3 signed product", product, exp);
        @(negedge clk); #1;
        check(product === exp && stall === 1'b0, "R6 hold with run high", product, exp);
        run = 1'b0;
        #1;
        check(stall === 1'b0, "R5 stall low without run", 64'(stall), 64'd0);
        @(negedge clk); #1;
        check(product === exp, "R6 hold after run low", product, exp);
    endtask

    task automatic abandon(input int cycles);
        @(negedge clk);
        op_a = $urandom; op_b = $urandom; mode_unsigned = 1'b0; run = 1'b1;
        repeat (cycles) @(negedge clk);
        run = 1'b0;
        #1;
        check(stall === 1'b0, "R7 abandon drops stall", 64'(stall), 64'd0);
        @(negedge clk); #1;
        check(stall === 1'b0, "R7 idle after abandon", 64'(stall), 64'd0);
    endtask

    initial begin
        logic [31:0] corners [6];
        corners[0] = 32'h0000_0000; corners[1] = 32'h0000_0001;
        corners[2] = 32'hFFFF_FFFF; corners[3] = 32'h8000_0000;
        corners[4] = 32'h7FFF_FFFF; corners[5] = 32'h0000_0002;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        #1;
        check(stall === 1'b0, "R1 reset stall", 64'(stall), 64'd0);
        check(product === 64'd0, "R1 reset product", product, 64'd0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check(stall === 1'b0 && product === 64'd0, "R1 idle after reset", product, 64'd0);

        for (int i = 0; i < 6; i++)
            for (int j = 0; j < 6; j++) begin
                do_mul(corners[i], corners[j], 1'b0, 1'b0);
                do_mul(corners[i], corners[j], 1'b1, 1'b0);
            end
        for (int k = 0; k < 40; k++) begin
            do_mul($urandom, $urandom, 1'b0, 1'b0);
            do_mul($urandom, $urandom, 1'b1, 1'b0);
        end
        do_mul(32'h8000_0000, 32'h8000_0000, 1'b0, 1'b1);
        do_mul(32'hDEAD_BEEF, 32'h1234_5678, 1'b1, 1'b1);
        do_mul($urandom, $urandom, 1'b0, 1'b1);

        abandon(10);
        do_mul(32'hFFFF_FFFE, 32'h0000_0003, 1'b0, 1'b0);
        abandon(31);
        do_mul(32'h8000_0000, 32'h7FFF_FFFF, 1'b0, 1'b0);
        abandon(1);
        do_mul(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b0);
        finished = 1;
    end

    initial begin
        int cyc = 0;
        while (!finished && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
        end
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end
endmodule